// File: doc/BRIEF.md
# Cyclic Gate Ring Evaluator

This block is a clocked evaluator for a closed ring of two-input gates. Gate types alternate between AND and OR around the ring. Every gate combines the output of the gate before it with one primary input. The ring contains a topological cycle, yet for any input vector some gates receive a controlling input. Those gates break the loop electrically, and the ring settles to definite values without holding any state.

A one-cycle start pulse latches the input vector and marks every gate output unknown. The engine then advances the whole ring by one unit-delay step per clock using three-valued logic. For each gate it records the step at which its output first became definite. Evaluation stops on the first step that changes nothing, or after a fixed maximum number of steps. The engine then raises done and reports whether every output resolved.

Top module: `cyc_ring_eval`

## Requirements
- R1: While reset is held and after it is released, done and settled are 0, every gate output reads unknown, and every arrival field reads all ones.
- R2: On the clock edge that samples start high, the block latches xIn, sets every gate output to unknown and every arrival field to all ones, and clears done.
- R3: Gates are numbered 0 to 2N-1. Gate i is an AND when i is even and an OR when i is odd. It takes primary input bit xIn[i mod N] and the output of gate (i-1) mod 2N. N is odd, so each input bit feeds one AND and one OR.
- R4: Each gate output is a 2-bit code at gateVal[2i+1:2i]: 00 means 0, 01 means 1, and bit 1 set means unknown. Gates follow Kleene rules: 0 controls AND, 1 controls OR, and an unknown operand otherwise gives unknown. A definite output never changes until the next start.
- R5: Each clock after start is one step, and the first step is numbered 0. arrTime[i*TW +: TW] holds the number of the step in which gate i first became definite. It stays all ones while the gate is unknown.
- R6: Evaluation ends after the first step that changes no gate output, or after step 2N-1, whichever comes first. done rises on the clock edge that completes that step.
- R7: After done rises, done, the gate outputs and the arrival fields hold unchanged until the next start.
- R8: settled is 1 exactly when done is 1 and no gate output is unknown. For every input vector, the result has settled = 1, and each gate equals the controlling value of the nearest controlled gate at or before it in ring order. Its arrival is the ring distance back to that gate.
- R9: A start during an evaluation abandons it and begins a fresh evaluation of the new vector.
- R10: Changes on xIn after the start edge have no effect on the running evaluation or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that latches xIn and begins evaluation |
| xIn | input | N | Primary input vector |
| gateVal | output | 4N | Ternary code of every gate output, two bits per gate |
| arrTime | output | 2N*TW | Arrival step of every gate, TW bits per gate |
| done | output | 1 | High from the end of evaluation until the next start |
| settled | output | 1 | High when done and every gate output is definite |

## Verification
The bench builds the block with N = 5, so the ring has ten gates. With this size, a run of up to five consecutive uncontrolled gates can occur, which exercises late arrival times and runs of several steps. All 32 input vectors are swept, and xIn is inverted during each run to test that inputs are latched. A behavioural model follows the ring step by step on every clock. A separate closed-form unrolling from the controlled gates predicts the final values and arrival times. A restart in the middle of a run is also exercised.

// File: rtl/cyc_ring_pkg.sv
package cyc_ring_pkg;
  typedef logic [1:0] tern_t;
  localparam tern_t TZERO = 2'b00;
  localparam tern_t TONE  = 2'b01;
  localparam tern_t TUNK  = 2'b10;

  typedef struct packed {
    logic clear;
    logic advance;
  } ring_ctl_t;

  function automatic logic tKnown(input tern_t a);
    return !a[1];
  endfunction

  function automatic tern_t tAnd(input tern_t a, input tern_t b);
    if ((tKnown(a) && !a[0]) || (tKnown(b) && !b[0])) return TZERO;
    if (tKnown(a) && tKnown(b)) return TONE;
    return TUNK;
  endfunction

  function automatic tern_t tOr(input tern_t a, input tern_t b);
    if ((tKnown(a) && a[0]) || (tKnown(b) && b[0])) return TONE;
    if (tKnown(a) && tKnown(b)) return TZERO;
    return TUNK;
  endfunction
endpackage

// File: rtl/cyc_ring_dp.sv
module cyc_ring_dp
  import cyc_ring_pkg::*;
#(
  parameter int N  = 3,
  parameter int G  = 2 * N,
  parameter int TW = $clog2(G) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  ring_ctl_t       ctl,
  input  logic [TW-1:0]   step,
  input  logic [N-1:0]    xIn,
  output logic [2*G-1:0]  gateVal,
  output logic [G*TW-1:0] arrTime,
  output logic            changed,
  output logic            allKnown
);
  logic [N-1:0] xLatch;
  tern_t        curVal [G];
  tern_t        nxtVal [G];
  logic [G-1:0] knownVec;
  logic [G-1:0] diffVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          xLatch <= '0;
    else if (ctl.clear) xLatch <= xIn;
  end

  for (genvar i = 0; i < G; i++) begin : g_gate
    localparam int PREV = (i + G - 1) % G;
    localparam int XSEL = i % N;
    tern_t xTern;
    logic [TW-1:0] arrQ;

    assign xTern = xLatch[XSEL] ? TONE : TZERO;

    if (i % 2 == 0) begin : g_and
      assign nxtVal[i] = tAnd(curVal[PREV], xTern);
    end else begin : g_or
      assign nxtVal[i] = tOr(curVal[PREV], xTern);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        curVal[i] <= TUNK;
        arrQ      <= '1;
      end else if (ctl.clear) begin
        curVal[i] <= TUNK;
        arrQ      <= '1;
      end else if (ctl.advance) begin
        if (!tKnown(curVal[i]) && tKnown(nxtVal[i])) arrQ <= step;
        curVal[i] <= nxtVal[i];
      end
    end

    assign knownVec[i]           = tKnown(curVal[i]);
    assign diffVec[i]            = (nxtVal[i] != curVal[i]);
    assign gateVal[2*i +: 2]     = curVal[i];
    assign arrTime[i*TW +: TW]   = arrQ;
  end

  assign changed  = |diffVec;
  assign allKnown = &knownVec;
endmodule

// File: rtl/cyc_ring_ctl.sv
module cyc_ring_ctl
  import cyc_ring_pkg::*;
#(
  parameter int N  = 3,
  parameter int G  = 2 * N,
  parameter int TW = $clog2(G) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          changed,
  output ring_ctl_t     ctl,
  output logic [TW-1:0] step,
  output logic          done
);
  localparam logic [TW-1:0] LAST = TW'(G - 1);
  logic busy;

  always_comb begin
    ctl.clear   = start;
    ctl.advance = busy && !start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      step <= '0;
    end else if (busy) begin
      step <= step + 1'b1;
      if (!changed || step == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cyc_ring_eval.sv
module cyc_ring_eval
  import cyc_ring_pkg::*;
#(
  parameter int N  = 3,
  parameter int G  = 2 * N,
  parameter int TW = $clog2(G) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [N-1:0]    xIn,
  output logic [2*G-1:0]  gateVal,
  output logic [G*TW-1:0] arrTime,
  output logic            done,
  output logic            settled
);
  ring_ctl_t     ctl;
  logic [TW-1:0] step;
  logic          changed;
  logic          allKnown;

  cyc_ring_ctl #(.N(N), .G(G), .TW(TW)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .changed(changed),
    .ctl(ctl), .step(step), .done(done)
  );

  cyc_ring_dp #(.N(N), .G(G), .TW(TW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .step(step), .xIn(xIn),
    .gateVal(gateVal), .arrTime(arrTime), .changed(changed), .allKnown(allKnown)
  );

  assign settled = done && allKnown;
endmodule

// File: rtl/cyc_ring_chk.sv
module cyc_ring_chk #(
  parameter int N  = 3,
  parameter int G  = 2 * N,
  parameter int TW = $clog2(G) + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [2*G-1:0]  gateVal,
  input logic [G*TW-1:0] arrTime,
  input logic            done,
  input logic            settled
);
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN) start |=> !done); // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN) (done && !start) |=> done); // R7
  AST_VALUES_FROZEN: assert property (@(posedge clk) disable iff (!rstN) (done && !start) |=> $stable(gateVal)); // R7
  AST_ARRIVAL_FROZEN: assert property (@(posedge clk) disable iff (!rstN) (done && !start) |=> $stable(arrTime)); // R7
  AST_SETTLED_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN) settled |-> done); // R8

  for (genvar i = 0; i < G; i++) begin : g_gate
    AST_DEFINITE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      (!start && !gateVal[2*i+1]) |=> $stable(gateVal[2*i +: 2])); // R4
    AST_ARRIVAL_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      (!start && !gateVal[2*i+1]) |=> $stable(arrTime[i*TW +: TW])); // R5
  end
endmodule

bind cyc_ring_eval cyc_ring_chk #(.N(N), .G(G), .TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .gateVal(gateVal),
  .arrTime(arrTime), .done(done), .settled(settled)
);

// File: tb/cyc_ring_eval_tb.sv
module cyc_ring_eval_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 5;
  localparam int G    = 2 * N;
  localparam int TW   = $clog2(G) + 1;
  localparam int MAXA = (1 << TW) - 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [N-1:0]    xIn = '0;
  logic [2*G-1:0]  gateVal;
  logic [G*TW-1:0] arrTime;
  logic            done;
  logic            settled;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural model state: 0, 1, or 2 for unknown
  int mVal [G];
  int mArr [G];
  int mX;
  int mBusy, mDone, mStep;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_ring_eval #(.N(N)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .xIn(xIn),
    .gateVal(gateVal), .arrTime(arrTime), .done(done), .settled(settled)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int kleene(input int isAnd, input int a, input int b);
    int ctrl = isAnd ? 0 : 1;
    if (a == ctrl || b == ctrl) return ctrl;
    if (a == 2 || b == 2) return 2;
    return 1 - ctrl;
  endfunction

  task automatic modelStep();
    int nv [G];
    int chg;
    if (!rstN) begin
      for (int i = 0; i < G; i++) begin mVal[i] = 2; mArr[i] = MAXA; end
      mBusy = 0; mDone = 0; mStep = 0; mX = 0;
    end else if (start) begin
      mX = int'(xIn);
      for (int i = 0; i < G; i++) begin mVal[i] = 2; mArr[i] = MAXA; end
      mBusy = 1; mDone = 0; mStep = 0;
    end else if (mBusy == 1) begin
      chg = 0;
      for (int i = 0; i < G; i++)
        nv[i] = kleene((i % 2 == 0) ? 1 : 0, mVal[(i + G - 1) % G], (mX >> (i % N)) & 1);
      for (int i = 0; i < G; i++) begin
        if (nv[i] != mVal[i]) chg = 1;
        if (mVal[i] == 2 && nv[i] != 2) mArr[i] = mStep;
      end
      for (int i = 0; i < G; i++) mVal[i] = nv[i];
      if (chg == 0 || mStep == G - 1) begin mBusy = 0; mDone = 1; end
      mStep++;
    end
  endtask

  task automatic compareAll();
    int allK = 1;
    for (int i = 0; i < G; i++) begin
      if (mVal[i] == 2) begin
        allK = 0;
        chk(gateVal[2*i+1] == 1'b1, "R4 unknown gate code", int'(gateVal[2*i +: 2]), 2);
      end else begin
        chk(int'(gateVal[2*i +: 2]) == mVal[i], "R4 gate value", int'(gateVal[2*i +: 2]), mVal[i]);
      end
      chk(int'(arrTime[i*TW +: TW]) == mArr[i], "R5 arrival step", int'(arrTime[i*TW +: TW]), mArr[i]);
    end
    chk(int'(done) == mDone, "R6 done timing", int'(done), mDone);
    chk(int'(settled) == ((mDone == 1 && allK == 1) ? 1 : 0), "R8 settled flag", int'(settled), mDone & allK);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finishRun();
    end
  endtask

  task automatic waitDone();
    int n = 0;
    while (done !== 1'b1) begin
      tick();
      n++;
      if (n > 4 * G) begin
        chk(1'b0, "R6 done never rose", n, 2 * G);
        return;
      end
    end
  endtask

  // closed-form unrolling from the controlled gates (R3, R8)
  task automatic checkClosedForm(input int v);
    for (int i = 0; i < G; i++) begin
      int d = 0;
      int j = i;
      int expV = 2;
      for (int k = 0; k < G; k++) begin
        int xb = (v >> (j % N)) & 1;
        int ctrlV = (j % 2 == 0) ? 0 : 1;
        if (xb == ctrlV) begin expV = ctrlV; break; end
        j = (j + G - 1) % G;
        d++;
      end
      chk(int'(gateVal[2*i +: 2]) == expV, "R3 unrolled value", int'(gateVal[2*i +: 2]), expV);
      chk(int'(arrTime[i*TW +: TW]) == d, "R8 unrolled arrival", int'(arrTime[i*TW +: TW]), d);
    end
    chk(settled == 1'b1, "R8 every vector settles", int'(settled), 1);
  endtask

  task automatic pulseStart(input int v);
    xIn = N'(v);
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  initial begin
    // R1: reset state
    tick(); tick();
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    rstN = 1'b1;
    tick();
    chk(settled == 1'b0, "R1 settled after reset", int'(settled), 0);
    chk(gateVal[1] == 1'b1, "R1 gate unknown after reset", int'(gateVal[1:0]), 2);

    // sweep all vectors; xIn inverted mid-run (R10), result held (R7)
    for (int v = 0; v < (1 << N); v++) begin
      pulseStart(v);
      chk(done == 1'b0, "R2 done cleared by start", int'(done), 0);
      chk(gateVal[2*G-1] == 1'b1, "R2 gates unknown after start", int'(gateVal[2*G-1 -: 2]), 2);
      xIn = ~N'(v);
      waitDone();
      checkClosedForm(v);
      tick(); tick();
      chk(done == 1'b1, "R7 done held", int'(done), 1);
      checkClosedForm(v);
    end

    // R9: restart while busy
    pulseStart(5'b00111);
    tick();
    chk(done == 1'b0, "R9 still busy before restart", int'(done), 0);
    pulseStart(5'b11000);
    waitDone();
    checkClosedForm(5'b11000);

    tick();
    finishRun();
  end
endmodule